// File: doc/BRIEF.md
# Parallel SAR converter interface controller

This block runs an external 12-bit successive-approximation converter that has a parallel output bus. It drives two active-low control lines, a chip select and a combined read/convert line, and watches the converter's asynchronous ready flag. The converter starts converting when both control lines are low. It drives its data bus only when read/convert is high, chip select is low and no conversion is running.

A conversion starts on a single-cycle request or runs by itself at a programmed rate. Every timing rule is given as a count of clock cycles on an input, so one netlist serves any clock frequency:

- the lead of the non-triggering control over the triggering one;
- the width of the convert pulse;
- the bus access delay before the word is captured;
- the minimum spacing between conversions;
- the free-running period;
- the bound on how long the converter may stay busy.

The ready flag is synchronised, and its rising edge marks a finished result. The controller then opens the bus, waits the access delay and presents the word as a signed two's complement sample with a one-cycle strobe.

A reduced-pin mode keeps chip select low. In that mode read/convert alone starts conversions and enables the bus.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While reset is held and right after it, adc_cs_n and adc_rdconv_n are 1, and sample_valid and timeout_err are 0.
- R2: In normal mode (reduced_pin=0) a conversion begins with adc_rdconv_n falling while adc_cs_n stays high. adc_cs_n falls exactly max(t_setup,1) cycles later, and that fall triggers the conversion.
- R3: Both control lines stay low together for exactly max(t_pulse,1) cycles. Then adc_rdconv_n returns high.
- R4: In normal mode adc_cs_n stays high from the end of the convert pulse until the converter reports ready again, so the bus is never enabled during a conversion. adc_cs_n is then low, with adc_rdconv_n high, for exactly max(t_access,1) cycles before the word is captured.
- R5: Each completed conversion gives exactly one single-cycle sample_valid pulse. sample_data carries the captured 12-bit bus word read as two's complement (0x800 is -2048, 0x7FF is +2047, 0xFFF is -1).
- R6: The cycle on which both controls first become low (a trigger) is more than t_space cycles after the previous trigger.
- R7: Start requests that arrive while a conversion or the spacing interval is pending are merged into one stored request. That request is serviced exactly once.
- R8: With free_run=1 and no start requests, conversions repeat, and consecutive triggers are more than max(t_space, t_rate) cycles apart.
- R9: In reduced-pin mode (reduced_pin=1) adc_cs_n is already low before the trigger. adc_rdconv_n alone starts the conversion, with no setup lead.
- R10: If no rising edge of adc_ready is seen within t_timeout cycles after the convert pulse ends, the controller sets timeout_err, gives no sample and returns to idle. timeout_err clears when the next conversion is launched.
- R11: adc_ready passes through a two-flop synchroniser. A captured word is taken only after a rising edge of the synchronised flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Single-cycle conversion request |
| free_run | input | 1 | Convert repeatedly without requests |
| reduced_pin | input | 1 | 1: chip select held low, read/convert does everything; change only while idle |
| t_setup | input | CNT_W | Cycles that read/convert leads chip select (normal mode) |
| t_pulse | input | CNT_W | Cycles both controls stay low |
| t_access | input | CNT_W | Cycles from opening the bus to capture |
| t_space | input | CNT_W | Minimum cycles between triggers |
| t_rate | input | CNT_W | Free-running period in cycles |
| t_timeout | input | CNT_W | Cycles allowed for ready to return |
| adc_ready | input | 1 | Asynchronous converter flag, low while converting |
| adc_data | input | DATA_W | Converter data bus |
| adc_cs_n | output | 1 | Chip select to converter, active low |
| adc_rdconv_n | output | 1 | Read/convert control, low requests conversion |
| sample_data | output | DATA_W | Signed captured sample |
| sample_valid | output | 1 | One-cycle strobe with each sample |
| timeout_err | output | 1 | Converter failed to report ready in time |

## Verification
The bench builds the block with its default parameters: CNT_W=12, DATA_W=12 and two synchroniser stages. It then drives small runtime counts: lead, pulse and access of 0 to 12 cycles, spacing of 60 to 150 cycles and a 60-cycle timeout. These values let a behavioural converter model, with a 30-cycle conversion, reach many conversions within the run.

The small counts bring several cases within reach: the zero-count floor of one cycle, the merging of requests that arrive while the spacing interval blocks a start, free-running spacing set by the rate rather than the spacing count, and a converter that never reports ready. The full-width and sign-boundary words 0x800, 0x7FF, 0x000 and 0xFFF are forced by the model before random words take over.

// File: rtl/sar_adc_pkg.sv
// Package: shared types for the parallel SAR converter controller.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_adc_pkg;

    // Controller sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LEAD   = 3'd1,
        ST_PULSE  = 3'd2,
        ST_CONV   = 3'd3,
        ST_ACCESS = 3'd4
    } conv_state_e;

endpackage

// File: rtl/sar_ready_sync.sv
// Module: sar_ready_sync
// Brings the converter's asynchronous ready flag into the clock domain through
// STAGES flops and flags its rising edge for one cycle.
// Assumes: ready is high while the converter is idle, so flops reset to 1.
module sar_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_i,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES:0] sh_q;

    // Shift the raw flag through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-1:0], ready_i};
    end

    assign rise_o = sh_q[LAST] & ~sh_q[STAGES];

    generate
        if (STAGES == 2) begin : g_chk2
            // R11: an edge is only reported once the raw flag was high two cycles ago
            a_r11_rise_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
                rise_o |-> $past(ready_i, 2));
        end
    endgenerate

endmodule

// File: rtl/sar_gap_timer.sv
// Module: sar_gap_timer
// Counts cycles since the last conversion trigger and reports when the next
// conversion may be launched, using the spacing count or, in free-running
// mode, the larger of spacing and rate.
// Assumes: trig_i is a one-cycle strobe on the cycle the trigger is driven.
module sar_gap_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             free_run_i,
    input  logic [CNT_W-1:0] t_space_i,
    input  logic [CNT_W-1:0] t_rate_i,
    output logic             gap_ok_o
);
    logic [CNT_W-1:0] elapsed_q;
    logic [CNT_W-1:0] limit;

    // Pick the active minimum distance.
    always_comb begin
        limit = t_space_i;
        if (free_run_i && (t_rate_i > t_space_i)) limit = t_rate_i;
    end

    // Saturating counter, restarted by each trigger, starts saturated.
    always_ff @(posedge clk) begin
        if (!rst_n)                 elapsed_q <= '1;
        else if (trig_i)            elapsed_q <= '0;
        else if (elapsed_q != '1)   elapsed_q <= elapsed_q + 1'b1;
    end

    assign gap_ok_o = (elapsed_q >= limit);

    // R6: right after a trigger the next launch is blocked when spacing is above one
    a_r6_gap_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && (t_space_i > 1)) |=> (!gap_ok_o || !$stable(t_space_i)));

endmodule

// File: rtl/sar_conv_fsm.sv
// Module: sar_conv_fsm
// Sequences the converter's control lines: lead, convert pulse, wait for
// ready, bus access and capture. It holds one merged pending request and
// watches for a converter that never finishes.
// Assumes: ready rise comes synchronised; mode only changes while idle.
module sar_conv_fsm
    import sar_adc_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_req_i,
    input  logic                     free_run_i,
    input  logic                     reduced_pin_i,
    input  logic [CNT_W-1:0]         t_setup_i,
    input  logic [CNT_W-1:0]         t_pulse_i,
    input  logic [CNT_W-1:0]         t_access_i,
    input  logic [CNT_W-1:0]         t_timeout_i,
    input  logic                     gap_ok_i,
    input  logic                     ready_rise_i,
    input  logic [DATA_W-1:0]        adc_data_i,
    output logic                     cs_n_o,
    output logic                     rdconv_n_o,
    output logic                     trig_o,
    output logic signed [DATA_W-1:0] sample_data_o,
    output logic                     sample_valid_o,
    output logic                     timeout_o
);
    localparam int CW1 = CNT_W + 1;

    conv_state_e       state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              pend_q;
    logic              mode_q;
    logic              launch;
    logic              req_any;
    logic              lead_done;
    logic              pulse_done;
    logic              access_done;
    logic              tmo_hit;

    // True once the counter has covered lim cycles (zero acts as one).
    function automatic logic reached(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] lim);
        return ({1'b0, c} + CW1'(1)) >= {1'b0, lim};
    endfunction

    // Decode launch and phase ends.
    always_comb begin
        req_any     = pend_q | start_req_i;
        launch      = (state_q == ST_IDLE) && gap_ok_i && (req_any || free_run_i);
        lead_done   = (state_q == ST_LEAD)   && reached(cnt_q, t_setup_i);
        pulse_done  = (state_q == ST_PULSE)  && reached(cnt_q, t_pulse_i);
        access_done = (state_q == ST_ACCESS) && reached(cnt_q, t_access_i);
        tmo_hit     = (state_q == ST_CONV)   && !ready_rise_i && reached(cnt_q, t_timeout_i);
        trig_o      = (launch && reduced_pin_i) || lead_done;
    end

    // Hold one merged request until a launch consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (launch) pend_q <= 1'b0;
        else             pend_q <= req_any;
    end

    // Main sequencer driving the control lines and capture register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= ST_IDLE;
            cnt_q          <= '0;
            mode_q         <= 1'b0;
            cs_n_o         <= 1'b1;
            rdconv_n_o     <= 1'b1;
            sample_data_o  <= '0;
            sample_valid_o <= 1'b0;
            timeout_o      <= 1'b0;
        end else begin
            sample_valid_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    cs_n_o <= ~reduced_pin_i;
                    mode_q <= reduced_pin_i;
                    cnt_q  <= '0;
                    if (launch) begin
                        timeout_o  <= 1'b0;
                        rdconv_n_o <= 1'b0;
                        if (reduced_pin_i) begin
                            cs_n_o  <= 1'b0;
                            state_q <= ST_PULSE;
                        end else begin
                            state_q <= ST_LEAD;
                        end
                    end
                end
                ST_LEAD: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (lead_done) begin
                        cs_n_o  <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= ST_PULSE;
                    end
                end
                ST_PULSE: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (pulse_done) begin
                        rdconv_n_o <= 1'b1;
                        cs_n_o     <= ~mode_q;
                        cnt_q      <= '0;
                        state_q    <= ST_CONV;
                    end
                end
                ST_CONV: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (ready_rise_i) begin
                        cs_n_o  <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= ST_ACCESS;
                    end else if (tmo_hit) begin
                        timeout_o <= 1'b1;
                        state_q   <= ST_IDLE;
                    end
                end
                ST_ACCESS: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (access_done) begin
                        sample_data_o  <= $signed(adc_data_i);
                        sample_valid_o <= 1'b1;
                        cs_n_o         <= ~mode_q;
                        state_q        <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: chip select only falls after read/convert has been low a cycle already
    a_r2_lead_order: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n_o) && ($past(state_q) == ST_LEAD)) |-> (!rdconv_n_o && $past(!rdconv_n_o)));

    // R4: bus stays disabled while a normal-mode conversion runs
    a_r4_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CONV) && !mode_q) |-> cs_n_o);

    // R5: strobe never lasts two cycles
    a_r5_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o |=> !sample_valid_o);

    // R9: reduced-pin mode keeps chip select low through the whole sequence
    a_r9_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && (state_q != ST_IDLE)) |-> !cs_n_o);

    // R10: the error flag is only raised out of the waiting state
    a_r10_timeout_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> ($past(state_q) == ST_CONV));

    // R3: the convert pulse ends with read/convert released
    a_r3_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) == ST_PULSE) && (state_q == ST_CONV)) |-> rdconv_n_o);

endmodule

// File: rtl/sar_adc_ctrl.sv
// Module: sar_adc_ctrl (top)
// Controller for an external parallel-output SAR converter: synchronises the
// ready flag, enforces spacing between conversions and sequences the
// control lines and data capture.
// Assumes: all timing inputs are quasi-static and change only while idle.
module sar_adc_ctrl #(
    parameter int CNT_W       = 12,
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_req,
    input  logic                     free_run,
    input  logic                     reduced_pin,
    input  logic [CNT_W-1:0]         t_setup,
    input  logic [CNT_W-1:0]         t_pulse,
    input  logic [CNT_W-1:0]         t_access,
    input  logic [CNT_W-1:0]         t_space,
    input  logic [CNT_W-1:0]         t_rate,
    input  logic [CNT_W-1:0]         t_timeout,
    input  logic                     adc_ready,
    input  logic [DATA_W-1:0]        adc_data,
    output logic                     adc_cs_n,
    output logic                     adc_rdconv_n,
    output logic signed [DATA_W-1:0] sample_data,
    output logic                     sample_valid,
    output logic                     timeout_err
);
    logic ready_rise;
    logic gap_ok;
    logic trig;

    sar_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready_i (adc_ready),
        .rise_o  (ready_rise)
    );

    sar_gap_timer #(.CNT_W(CNT_W)) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig),
        .free_run_i (free_run),
        .t_space_i  (t_space),
        .t_rate_i   (t_rate),
        .gap_ok_o   (gap_ok)
    );

    sar_conv_fsm #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_req_i    (start_req),
        .free_run_i     (free_run),
        .reduced_pin_i  (reduced_pin),
        .t_setup_i      (t_setup),
        .t_pulse_i      (t_pulse),
        .t_access_i     (t_access),
        .t_timeout_i    (t_timeout),
        .gap_ok_i       (gap_ok),
        .ready_rise_i   (ready_rise),
        .adc_data_i     (adc_data),
        .cs_n_o         (adc_cs_n),
        .rdconv_n_o     (adc_rdconv_n),
        .trig_o         (trig),
        .sample_data_o  (sample_data),
        .sample_valid_o (sample_valid),
        .timeout_o      (timeout_err)
    );

    // R1: outputs idle in the first cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(!rst_n) |-> (adc_rdconv_n && !sample_valid && !timeout_err));

endmodule

// File: tb/sar_adc_ctrl_tb_top.sv
// Bench: behavioural converter model plus monitors, directed and random runs.
module sar_adc_ctrl_tb_top;
    localparam int CNT_W    = 12;
    localparam int DATA_W   = 12;
    localparam int CONV_CYC = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0, free_run = 1'b0, reduced_pin = 1'b0;
    logic [CNT_W-1:0] t_setup = 3, t_pulse = 10, t_access = 4, t_space = 80, t_rate = 0, t_timeout = 200;
    logic adc_ready;
    logic [DATA_W-1:0] adc_data;
    logic adc_cs_n, adc_rdconv_n, sample_valid, timeout_err;
    logic signed [DATA_W-1:0] sample_data;

    int checks = 0, errors = 0;
    int cyc = 0, conv_count = 0, samples = 0;
    logic hang = 1'b0;
    logic conv_active = 1'b0, busy_m = 1'b1, viol = 1'b0;
    logic [DATA_W-1:0] out_reg = '0;
    int conv_left = 0, dir_idx = 0;
    int last_trig = 0;
    bit have_last = 0;
    int setup_run = 0, pulse_run = 0, acc_run = 0;
    logic prev_both = 1'b0, prev_cs_n = 1'b1, prev_valid = 1'b0;

    always #2 clk = ~clk;

    sar_adc_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .free_run(free_run),
        .reduced_pin(reduced_pin), .t_setup(t_setup), .t_pulse(t_pulse),
        .t_access(t_access), .t_space(t_space), .t_rate(t_rate), .t_timeout(t_timeout),
        .adc_ready(adc_ready), .adc_data(adc_data), .adc_cs_n(adc_cs_n),
        .adc_rdconv_n(adc_rdconv_n), .sample_data(sample_data),
        .sample_valid(sample_valid), .timeout_err(timeout_err)
    );

    assign adc_ready = busy_m;
    assign adc_data  = (adc_rdconv_n && !adc_cs_n && !conv_active) ? out_reg : 12'h5A5;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int lim_now();
        if (free_run && (t_rate > t_space)) return int'(t_rate);
        return int'(t_space);
    endfunction

    function automatic logic [DATA_W-1:0] pick();
        logic [DATA_W-1:0] v;
        case (dir_idx)
            0: v = 12'h800;
            1: v = 12'h7FF;
            2: v = 12'h000;
            3: v = 12'hFFF;
            default: v = DATA_W'($urandom);
        endcase
        dir_idx++;
        return v;
    endfunction

    // Converter model and protocol monitors, sampled on the falling edge.
    always @(negedge clk) begin
        logic both;
        cyc++;
        both = !adc_cs_n && !adc_rdconv_n;
        if (!rst_n) begin
            conv_active = 0; busy_m = 1; prev_both = 0; prev_valid = 0;
            setup_run = 0; pulse_run = 0; acc_run = 0;
        end else begin
            if (both && !prev_both) begin
                conv_count++;
                if (have_last)
                    chk((cyc - last_trig) > lim_now(), free_run ? "R8" : "R6",
                        "trigger spacing", cyc - last_trig, lim_now() + 1);
                last_trig = cyc; have_last = 1;
                if (!reduced_pin)
                    chk(setup_run == eff(int'(t_setup)), "R2", "lead cycles", setup_run, eff(int'(t_setup)));
                else
                    chk(prev_cs_n == 1'b0, "R9", "cs low before trigger", int'(prev_cs_n), 0);
                conv_active = 1; conv_left = CONV_CYC; viol = 0; pulse_run = 0; acc_run = 0;
            end else if (conv_active) begin
                conv_left--;
                if (conv_left == CONV_CYC - 2) busy_m = 0;
                if (conv_left == 0) begin
                    out_reg = pick();
                    conv_active = 0;
                    if (!hang) busy_m = 1;
                    if (!reduced_pin) chk(!viol, "R4", "bus enabled during conversion", int'(viol), 0);
                end
            end
            if (both) pulse_run++;
            if (!both && prev_both)
                chk(pulse_run == eff(int'(t_pulse)), "R3", "pulse cycles", pulse_run, eff(int'(t_pulse)));
            if (!adc_rdconv_n && adc_cs_n) setup_run++;
            else if (adc_rdconv_n) setup_run = 0;
            if (!reduced_pin && conv_active && !adc_cs_n && adc_rdconv_n) viol = 1;
            if (sample_valid) begin
                samples++;
                chk(sample_data == $signed(out_reg), "R5", "sample value", int'(sample_data), int'($signed(out_reg)));
                chk(!prev_valid, "R5", "strobe width", int'(prev_valid), 0);
                if (!reduced_pin)
                    chk(acc_run == eff(int'(t_access)), "R4", "access cycles", acc_run, eff(int'(t_access)));
                acc_run = 0;
            end
            if (!reduced_pin && adc_rdconv_n && !adc_cs_n) acc_run++;
            prev_both = both; prev_cs_n = adc_cs_n; prev_valid = sample_valid;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
    endtask

    task automatic do_conv(input string req);
        int s0 = samples;
        pulse_start();
        for (int i = 0; i < 2000 && samples == s0; i++) @(negedge clk);
        chk(samples == s0 + 1, req, "sample count", samples - s0, 1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int c0, s0;
        void'($urandom(32'd1234));
        idle(3);
        chk(adc_cs_n && adc_rdconv_n && !sample_valid && !timeout_err, "R1", "outputs in reset", 0, 0);
        @(negedge clk) rst_n = 1'b1;
        idle(1);
        chk(adc_cs_n && adc_rdconv_n && !sample_valid && !timeout_err, "R1", "outputs after reset", 0, 0);

        // Directed sign-boundary words.
        for (int k = 0; k < 4; k++) begin
            do_conv("R5");
            if (k == 0) chk(sample_data == -12'sd2048, "R5", "0x800 reads as -2048", int'(sample_data), -2048);
            if (k == 3) chk(sample_data == -12'sd1, "R5", "0xFFF reads as -1", int'(sample_data), -1);
        end

        // Zero counts fall back to one cycle.
        t_setup = 0; t_pulse = 0; t_access = 0;
        do_conv("R3");
        t_setup = 3; t_pulse = 10; t_access = 4;
        idle(100);

        // Requests merged while busy (R7).
        c0 = conv_count;
        pulse_start();
        idle(6);
        for (int k = 0; k < 3; k++) begin pulse_start(); idle(4); end
        idle(700);
        chk(conv_count - c0 == 2, "R7", "conversions from merged requests", conv_count - c0, 2);

        // Converter that never reports ready (R10).
        hang = 1; t_timeout = 60;
        s0 = samples;
        pulse_start();
        idle(300);
        chk(timeout_err == 1'b1, "R10", "timeout flag", int'(timeout_err), 1);
        chk(samples == s0, "R10", "no sample after timeout", samples - s0, 0);
        hang = 0; t_timeout = 200;
        do_conv("R10");
        chk(timeout_err == 1'b0, "R10", "flag cleared on next launch", int'(timeout_err), 0);
        idle(100);

        // Reduced-pin mode (R9).
        reduced_pin = 1; idle(3);
        for (int k = 0; k < 3; k++) begin do_conv("R9"); idle(90); end
        reduced_pin = 0; idle(5);

        // Free running at a rate above spacing (R8).
        c0 = conv_count; t_rate = 150;
        @(negedge clk) free_run = 1'b1;
        idle(1200);
        @(negedge clk) free_run = 1'b0;
        chk(conv_count - c0 >= 5, "R8", "free-running conversions", conv_count - c0, 5);
        idle(300);

        // Random timing and mode mix (R11 covered by every capture after ready rise).
        for (int k = 0; k < 20; k++) begin
            t_setup = CNT_W'(1 + $urandom_range(0, 5));
            t_pulse = CNT_W'(1 + $urandom_range(0, 11));
            t_access = CNT_W'(1 + $urandom_range(0, 5));
            t_space = CNT_W'(60 + $urandom_range(0, 60));
            reduced_pin = ($urandom_range(0, 3) == 0);
            idle(3);
            do_conv("R11");
            idle(130);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(150000 * 4);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

endmodule